// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sits beside the CPU of a small 8-bit controller and turns one CPU-writable power control byte into clock enables. Setting the idle bit stops the CPU clock but keeps the peripheral clocks running. Setting the power-down bit stops both. An active enabled interrupt clears idle in hardware. A watchdog overflow pulse, or an external reset held long enough, produces an internal reset. That reset restores every register of the block to its reset value.

A separate one-bit sleep control gates the clock of an attached bus controller. Software sets and clears the bit and can read it back. A dominant (low) level on either bus receive line, after synchronization, clears the bit in hardware and wakes the controller. All pins are plain control and status signals. Nothing in this block carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset `ctl_rdata` reads 0x00, `sleep_rdata` is 0, `cpu_clk_en`, `per_clk_en` and `bus_clk_en` are 1, and `int_rst` is 0.
- R2: A write stores bits 7 (baud double), 5 (watchdog load enable), 4 and 3 (general flags), 1 (power-down) and 0 (idle). It is visible on `ctl_rdata` after the next clock edge. Bits 6 and 2 always read 0.
- R3: When bits 1 and 0 are both written 1 and power-down is permitted, bit 1 is stored, bit 0 reads 0, and both `cpu_clk_en` and `per_clk_en` go low.
- R4: While `pd_allow` is low, writing 1 to bit 1 leaves bit 1 unchanged; the other written bits still take effect.
- R5: A `wdt_reload` strobe clears bit 5 at the next edge, even if the same cycle writes it to 1.
- R6: With bit 0 set, `cpu_clk_en` is 0 and `per_clk_en` is 1. An active `irq_active` clears bit 0 at the next edge, and the other bits keep their values.
- R7: A one-cycle `wdt_ovf` pulse makes `int_rst` high for exactly the next cycle. At that same edge the control byte and the sleep bit return to their reset values.
- R8: `ext_rst` asserts the internal reset only after it has been sampled high on RST_QUAL_CYC (default 24) consecutive edges. `int_rst` rises at that edge. A shorter pulse changes nothing.
- R9: Writing the sleep bit sets or clears it. `sleep_rdata` returns it, and `bus_clk_en` is its inverse.
- R10: A low level on `rx_a` or `rx_b` clears the sleep bit SYNC_STAGES+1 edges after the line goes low.
- R11: `irq_active` does not clear the power-down bit; the clocks stay off until software or a reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ctl_wr_en | input | 1 | Write strobe for the power control byte |
| ctl_wdata | input | 8 | Write data for the power control byte |
| ctl_rdata | output | 8 | Current power control byte |
| pd_allow | input | 1 | Permits setting the power-down bit |
| wdt_reload | input | 1 | Watchdog reload strobe, clears the load-enable bit |
| irq_active | input | 1 | An enabled interrupt is pending |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| ext_rst | input | 1 | External reset request, active high |
| sleep_wr_en | input | 1 | Write strobe for the bus sleep bit |
| sleep_wdata | input | 1 | Write value for the bus sleep bit |
| sleep_rdata | output | 1 | Current bus sleep bit |
| rx_a | input | 1 | Bus receive line A, low is dominant |
| rx_b | input | 1 | Bus receive line B, low is dominant |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| bus_clk_en | output | 1 | Bus controller clock enable |
| int_rst | output | 1 | Internal reset pulse, active high |

## Verification
The bench builds the block with RST_QUAL_CYC = 24 and SYNC_STAGES = 2. These are the values the requirements describe. With them, pulses of 23 and 24 cycles can be placed exactly either side of the reset qualification threshold. The bus wake can also be sampled on the exact edge where it should first appear. A random phase then mixes writes, the power-down permit, reload strobes and interrupts. This exercises the ordering between software writes and hardware clears.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int CTL_W     = 8;
  localparam int BIT_BAUD2 = 7;
  localparam int BIT_WDLD  = 5;
  localparam int BIT_FLAG1 = 4;
  localparam int BIT_FLAG0 = 3;
  localparam int BIT_PDN   = 1;
  localparam int BIT_IDLE  = 0;
  // writable bits of the control byte; the others read zero
  localparam logic [CTL_W-1:0] CTL_MASK =
    CTL_W'((1 << BIT_BAUD2) | (1 << BIT_WDLD) | (1 << BIT_FLAG1) |
           (1 << BIT_FLAG0) | (1 << BIT_PDN) | (1 << BIT_IDLE));
endpackage

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  input  logic             pd_allow,
  input  logic             wdt_reload,
  input  logic             irq_active,
  output logic [CTL_W-1:0] ctl_q
);
  logic [CTL_W-1:0] ctl_nxt;

  always_comb begin
    ctl_nxt = ctl_q;
    if (wr_en) begin
      ctl_nxt = wdata & CTL_MASK;
      // setting power-down needs the permit; clearing never does
      if (!pd_allow && wdata[BIT_PDN]) ctl_nxt[BIT_PDN] = ctl_q[BIT_PDN];
      // power-down wins over idle
      if (ctl_nxt[BIT_PDN]) ctl_nxt[BIT_IDLE] = 1'b0;
    end
    if (wdt_reload) ctl_nxt[BIT_WDLD] = 1'b0;
    if (irq_active && ctl_q[BIT_IDLE]) ctl_nxt[BIT_IDLE] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ctl_q <= '0;
    else if (clr) ctl_q <= '0;
    else          ctl_q <= ctl_nxt;
  end
endmodule

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
  parameter int QUAL_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_rst,
  output logic rst_req
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(QUAL_CYC);
  localparam logic [CW-1:0] CNT_TRIG = CW'(QUAL_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!ext_rst)       cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // true on the edge that samples ext_rst high for the QUAL_CYC-th time
  assign rst_req = ext_rst && (cnt >= CNT_TRIG);
endmodule

// File: rtl/bus_sleep.sv
module bus_sleep #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_en,
  input  logic wdata,
  input  logic rx_a,
  input  logic rx_b,
  output logic sleep_q
);
  localparam int NRX = 2;

  logic [NRX-1:0] rx_in;
  logic [NRX-1:0] rx_sync;
  logic           dominant;

  assign rx_in = {rx_b, rx_a};

  for (genvar g = 0; g < NRX; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else begin
        chain[0] <= rx_in[g];
        for (int s = 1; s < SYNC_STAGES; s++) chain[s] <= chain[s-1];
      end
    end
    assign rx_sync[g] = chain[SYNC_STAGES-1];
  end

  assign dominant = ~&rx_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sleep_q <= 1'b0;
    else if (clr)      sleep_q <= 1'b0;
    else if (dominant) sleep_q <= 1'b0;
    else if (wr_en)    sleep_q <= wdata;
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int RST_QUAL_CYC = 24,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             pd_allow,
  input  logic             wdt_reload,
  input  logic             irq_active,
  input  logic             wdt_ovf,
  input  logic             ext_rst,
  input  logic             sleep_wr_en,
  input  logic             sleep_wdata,
  output logic             sleep_rdata,
  input  logic             rx_a,
  input  logic             rx_b,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             bus_clk_en,
  output logic             int_rst
);
  logic             ext_req;
  logic             rst_req;
  logic [CTL_W-1:0] ctl_q;
  logic             sleep_q;

  rst_qualifier #(.QUAL_CYC(RST_QUAL_CYC)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_rst (ext_rst),
    .rst_req (ext_req)
  );

  assign rst_req = ext_req | wdt_ovf;

  pwr_ctl_reg u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (rst_req),
    .wr_en      (ctl_wr_en),
    .wdata      (ctl_wdata),
    .pd_allow   (pd_allow),
    .wdt_reload (wdt_reload),
    .irq_active (irq_active),
    .ctl_q      (ctl_q)
  );

  bus_sleep #(.SYNC_STAGES(SYNC_STAGES)) u_sleep (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (rst_req),
    .wr_en   (sleep_wr_en),
    .wdata   (sleep_wdata),
    .rx_a    (rx_a),
    .rx_b    (rx_b),
    .sleep_q (sleep_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_rst <= 1'b0;
    else        int_rst <= rst_req;
  end

  assign ctl_rdata   = ctl_q;
  assign sleep_rdata = sleep_q;
  assign cpu_clk_en  = ~(ctl_q[BIT_IDLE] | ctl_q[BIT_PDN]);
  assign per_clk_en  = ~ctl_q[BIT_PDN];
  assign bus_clk_en  = ~sleep_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr_en,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       pd_allow,
  input logic       wdt_reload,
  input logic       irq_active,
  input logic       wdt_ovf,
  input logic       ext_rst,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       int_rst
);
  // R3: permitted power-down write stops both clocks
  a_r3_pd_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && ctl_wdata[1] && pd_allow && !wdt_ovf && !ext_rst)
      |=> (!cpu_clk_en && !per_clk_en));

  // R4: without the permit, power-down cannot appear
  a_r4_pd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_allow && per_clk_en) |=> per_clk_en);

  // R5: reload strobe clears the load-enable bit
  a_r5_wdld_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reload |=> !ctl_rdata[5]);

  // R6: interrupt in idle restores the CPU clock
  a_r6_irq_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_active && !cpu_clk_en && per_clk_en && !ctl_wr_en) |=> cpu_clk_en);

  // R7: watchdog overflow yields reset and clears the byte
  a_r7_wdt_reset: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_ovf |=> (int_rst && ctl_rdata == 8'h00));

  // R8: internal reset only follows a reset source
  a_r8_rst_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_rst) |-> ($past(wdt_ovf) || $past(ext_rst)));

  // R11: interrupts never release power-down
  a_r11_pd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_clk_en && !ctl_wr_en && !wdt_ovf && !ext_rst) |=> !per_clk_en);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr_en  (ctl_wr_en),
  .ctl_wdata  (ctl_wdata),
  .ctl_rdata  (ctl_rdata),
  .pd_allow   (pd_allow),
  .wdt_reload (wdt_reload),
  .irq_active (irq_active),
  .wdt_ovf    (wdt_ovf),
  .ext_rst    (ext_rst),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .int_rst    (int_rst)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int QUAL = 24;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr_en = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       pd_allow = 1'b0;
  logic       wdt_reload = 1'b0;
  logic       irq_active = 1'b0;
  logic       wdt_ovf = 1'b0;
  logic       ext_rst = 1'b0;
  logic       sleep_wr_en = 1'b0;
  logic       sleep_wdata = 1'b0;
  logic       sleep_rdata;
  logic       rx_a = 1'b1;
  logic       rx_b = 1'b1;
  logic       cpu_clk_en, per_clk_en, bus_clk_en, int_rst;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.RST_QUAL_CYC(QUAL), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .pd_allow(pd_allow), .wdt_reload(wdt_reload),
    .irq_active(irq_active), .wdt_ovf(wdt_ovf), .ext_rst(ext_rst),
    .sleep_wr_en(sleep_wr_en), .sleep_wdata(sleep_wdata),
    .sleep_rdata(sleep_rdata), .rx_a(rx_a), .rx_b(rx_b),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .bus_clk_en(bus_clk_en), .int_rst(int_rst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_wr_en = 1'b1; ctl_wdata = d;
    tick();
    ctl_wr_en = 1'b0;
  endtask

  task automatic wr_sleep(input logic d);
    sleep_wr_en = 1'b1; sleep_wdata = d;
    tick();
    sleep_wr_en = 1'b0;
  endtask

  // expected next control byte, built from R2..R6 and R11
  function automatic logic [7:0] model(input logic [7:0] cur, input logic wr,
      input logic [7:0] d, input logic allow, input logic rel, input logic irq);
    logic [7:0] n;
    n = cur;
    if (wr) begin
      n = d & 8'hBB;
      if (!allow && d[1]) n[1] = cur[1];
      if (n[1]) n[0] = 1'b0;
    end
    if (rel) n[5] = 1'b0;
    if (irq && cur[0]) n[0] = 1'b0;
    return n;
  endfunction

  function automatic logic [1:0] clk_model(input logic [7:0] r);
    return {~r[1], ~(r[0] | r[1])};  // {per, cpu}
  endfunction

  initial begin
    #(CLK_PERIOD * 50000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] exp_r;
    logic [1:0] ce;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    check(ctl_rdata == 8'h00, "R1 ctl", ctl_rdata, 0);
    check(cpu_clk_en && per_clk_en && bus_clk_en && !int_rst && !sleep_rdata,
          "R1 outputs", {cpu_clk_en, per_clk_en, bus_clk_en, int_rst, sleep_rdata}, 5'b11100);

    // R2 R4 R6: all ones without permit -> B9, idle set
    pd_allow = 1'b0;
    wr_ctl(8'hFF);
    check(ctl_rdata == 8'hB9, "R2 R4 readback", ctl_rdata, 8'hB9);
    check(!cpu_clk_en && per_clk_en, "R6 idle clocks", {cpu_clk_en, per_clk_en}, 2'b01);

    // R6 interrupt clears idle only
    irq_active = 1'b1; tick(); irq_active = 1'b0;
    check(ctl_rdata == 8'hB8 && cpu_clk_en, "R6 irq wake", ctl_rdata, 8'hB8);

    // R5 reload beats a write of 1
    wdt_reload = 1'b1; wr_ctl(8'hA0); wdt_reload = 1'b0;
    check(ctl_rdata == 8'h80, "R5 reload clear", ctl_rdata, 8'h80);

    // R3 power-down and idle together
    pd_allow = 1'b1;
    wr_ctl(8'h03);
    check(ctl_rdata == 8'h02, "R3 pd wins", ctl_rdata, 8'h02);
    check(!cpu_clk_en && !per_clk_en, "R3 clocks off", {cpu_clk_en, per_clk_en}, 0);

    // R11 interrupt leaves power-down set
    irq_active = 1'b1; tick(); irq_active = 1'b0;
    check(ctl_rdata == 8'h02 && !per_clk_en, "R11 pd holds", ctl_rdata, 8'h02);
    wr_ctl(8'h00);

    // R9 sleep bit
    wr_sleep(1'b1);
    check(sleep_rdata && !bus_clk_en, "R9 sleep set", sleep_rdata, 1);

    // R7 watchdog overflow
    wr_ctl(8'h98);
    wdt_ovf = 1'b1; tick(); wdt_ovf = 1'b0;
    check(int_rst && ctl_rdata == 8'h00 && !sleep_rdata, "R7 wdt reset",
          {int_rst, ctl_rdata}, 9'h100);
    tick();
    check(!int_rst, "R7 one cycle", int_rst, 0);

    // R8 short pulse rejected
    wr_ctl(8'h18);
    ext_rst = 1'b1;
    repeat (QUAL - 1) tick();
    check(!int_rst && ctl_rdata == 8'h18, "R8 short pulse", {int_rst, ctl_rdata}, 9'h018);
    ext_rst = 1'b0; tick();
    ext_rst = 1'b1;
    repeat (QUAL - 1) tick();
    check(!int_rst, "R8 before threshold", int_rst, 0);
    tick();
    check(int_rst && ctl_rdata == 8'h00, "R8 qualified", {int_rst, ctl_rdata}, 9'h100);
    ext_rst = 1'b0; tick(); tick();

    // R10 wake on either line
    wr_sleep(1'b1);
    rx_a = 1'b0;
    repeat (SYNC) tick();
    check(sleep_rdata, "R10 not yet", sleep_rdata, 1);
    tick();
    check(!sleep_rdata && bus_clk_en, "R10 wake a", sleep_rdata, 0);
    rx_a = 1'b1; repeat (SYNC + 1) tick();
    wr_sleep(1'b1);
    rx_b = 1'b0; repeat (SYNC + 1) tick();
    check(!sleep_rdata, "R10 wake b", sleep_rdata, 0);
    rx_b = 1'b1; repeat (SYNC + 1) tick();
    wr_sleep(1'b1);
    wr_sleep(1'b0);
    check(!sleep_rdata && bus_clk_en, "R9 sleep clear", sleep_rdata, 0);

    // random mix against the model (R2 R4 R5 R6 R11)
    exp_r = ctl_rdata;
    for (int i = 0; i < 400; i++) begin
      ctl_wr_en  = ($urandom % 3) == 0;
      ctl_wdata  = 8'($urandom);
      pd_allow   = $urandom % 2;
      wdt_reload = ($urandom % 5) == 0;
      irq_active = ($urandom % 4) == 0;
      exp_r = model(exp_r, ctl_wr_en, ctl_wdata, pd_allow, wdt_reload, irq_active);
      tick();
      ce = clk_model(exp_r);
      check(ctl_rdata == exp_r, "R2 random byte", ctl_rdata, exp_r);
      check({per_clk_en, cpu_clk_en} == ce, "R6 random clocks",
            {per_clk_en, cpu_clk_en}, ce);
    end
    ctl_wr_en = 1'b0; wdt_reload = 1'b0; irq_active = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule